// File: doc/BRIEF.md
# Indexed Configuration RAM with Self-Filling Checksum

This block holds 64 bytes of configuration data behind two ports that share one request channel. One port holds an index register. The other port reads or writes the byte that the index selects. Each byte takes its value at reset from an arithmetic fill rule. The top module has no memory initialisation file.

The first data-port request after reset does not complete at once. It starts a sequencer that adds up the bytes from 0x10 to 0x2C, one byte per clock, in a 16-bit accumulator that wraps on overflow. The sequencer writes the high byte of the result to 0x2E and the low byte to 0x2F. The stalled request then completes. Later data-port writes store their byte and nothing more. Index-port requests never start the pass.

The request channel is valid/ready. The requester holds `req_valid` and its fields steady until it samples `req_ready` high at a rising edge. A request with `req_valid` high and `req_ready` high at an edge is accepted there. `req_ready` is low while the pass runs. It is also low while an uninitialised data request waits for the pass. The read response has no back-pressure: `rsp_valid` pulses for one cycle and the requester must take the data then.

Top module: `cfgram_indexed`

## Requirements
- R1: After reset, `busy` and `init_done` are 0, `rsp_valid` is 0, and an index-port request (`req_sel`=0) sees `req_ready`=1.
- R2: An accepted index write (`req_sel`=0, `req_write`=1) stores `req_wdata[6:0]`. An index read returns that value with bit 7 zero.
- R3: A data-port access (`req_sel`=1) addresses byte `index[5:0]`, so index 0x45 reaches byte 0x05 and index 0x7F reaches byte 0x3F.
- R4: After reset, byte `a` holds `(29*a + 17) mod 256`.
- R5: The first data request after reset raises `busy` on the next edge and holds it for exactly 29 cycles. `req_ready` stays low until `busy` falls, and then the request is accepted.
- R6: The pass stores the 16-bit wrapping sum of bytes 0x10..0x2C inclusive: the high byte at 0x2E and the low byte at 0x2F.
- R7: The pass completes before the stalled first access takes effect. A first write to a summed byte does not change the stored sum. A first write to 0x2F overwrites the low sum byte.
- R8: Once `init_done` is 1, it stays 1 until reset. Later data accesses complete with no `busy` cycle, and later writes leave 0x2E/0x2F unchanged.
- R9: Index-port requests before initialisation do not start the pass: `busy` and `init_done` stay 0.
- R10: An accepted read gives `rsp_valid`=1 with `rsp_rdata` on the cycle after the accepting edge. An accepted write gives no response pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle pulse carrying read data |
| rsp_rdata | output | 8 | Read data |
| busy | output | 1 | Checksum pass in progress |
| init_done | output | 1 | Checksum pass has completed since reset |

## Verification
The bench drives each request just after a falling edge. It then counts the falling edges on which `busy` is high while `req_ready` stays low, and expects that count to be 29 for the first data request and 0 for every later one. The accepting rising edge follows. Read data is sampled one falling edge later, which is the cycle after acceptance where `rsp_valid` is due. Write results are confirmed through a separate read.

// File: rtl/cfgram_pkg.sv
package cfgram_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_SUM  = 1'b1
  } seq_state_e;

  // Reset-time fill rule: byte a = (mul*a + add) truncated by the caller.
  function automatic logic [31:0] fill_value(input int unsigned addr,
                                             input int unsigned mul,
                                             input int unsigned add);
    int unsigned t;
    t = addr * mul + add;
    return t;
  endfunction

endpackage

// File: rtl/cfgram_store.sv
module cfgram_store #(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 8,
  parameter int SUM_W      = 16,
  parameter int FILL_MUL   = 29,
  parameter int FILL_ADD   = 17,
  parameter int CK_HI_ADDR = 'h2E,
  parameter int CK_LO_ADDR = 'h2F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [ADDR_W-1:0] seq_addr,
  output logic [DATA_W-1:0] seq_rdata,
  input  logic              ck_we,
  input  logic [SUM_W-1:0]  ck_value
);
  import cfgram_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= DATA_W'(fill_value(i, FILL_MUL, FILL_ADD));
    end else if (ck_we) begin
      mem[CK_HI_ADDR] <= ck_value[SUM_W-1 -: DATA_W];
      mem[CK_LO_ADDR] <= ck_value[DATA_W-1:0];
    end else if (bus_we) begin
      mem[bus_addr] <= bus_wdata;
    end
  end

  assign bus_rdata = mem[bus_addr];
  assign seq_rdata = mem[seq_addr];

  // R7: the checksum store never coincides with a bus write
  assert_ck_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ck_we |-> !bus_we);

endmodule

// File: rtl/cfgram_sumseq.sv
module cfgram_sumseq #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int SUM_W  = 16,
  parameter int SUM_LO = 'h10,
  parameter int SUM_HI = 'h2C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic [ADDR_W-1:0] seq_addr_o,
  input  logic [DATA_W-1:0] seq_rdata_i,
  output logic              ck_we_o,
  output logic [SUM_W-1:0]  ck_value_o,
  output logic              busy_o,
  output logic              init_o
);
  import cfgram_pkg::*;

  localparam int SUM_LEN = SUM_HI - SUM_LO + 1;
  localparam int RUN_W   = $clog2(SUM_LEN + 2);

  seq_state_e        state_q;
  logic [ADDR_W-1:0] idx_q;
  logic [SUM_W-1:0]  acc_q;
  logic              init_q;
  logic [SUM_W-1:0]  sum_next;
  logic              last_step;

  assign sum_next  = acc_q + SUM_W'(seq_rdata_i);
  assign last_step = (state_q == SEQ_SUM) && (idx_q == ADDR_W'(SUM_HI));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= ADDR_W'(SUM_LO);
      acc_q   <= '0;
      init_q  <= 1'b0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (start_i && !init_q) begin
            state_q <= SEQ_SUM;
            idx_q   <= ADDR_W'(SUM_LO);
            acc_q   <= '0;
          end
        end
        SEQ_SUM: begin
          acc_q <= sum_next;
          if (last_step) begin
            state_q <= SEQ_IDLE;
            init_q  <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign seq_addr_o = idx_q;
  assign ck_we_o    = last_step;
  assign ck_value_o = sum_next;
  assign busy_o     = (state_q == SEQ_SUM);
  assign init_o     = init_q;

  // Checker support: length of the current busy run.
  logic [RUN_W-1:0] run_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_cnt <= '0;
    else if (busy_o) run_cnt <= run_cnt + 1'b1;
    else             run_cnt <= '0;
  end

  // R5: each pass keeps busy high for exactly SUM_LEN cycles
  assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (run_cnt == RUN_W'(SUM_LEN)));

  // R8: init_done is sticky
  assert_init_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    init_q |=> init_q);

  // R8: no second pass after initialisation
  assert_no_repass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    init_q |-> !busy_o);

endmodule

// File: rtl/cfgram_front.sv
module cfgram_front #(
  parameter int IDX_W  = 7,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_sel,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              init_i,
  input  logic              seq_idle_i,
  output logic              start_o,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic [IDX_W-1:0] idx_q;
  logic             accept;

  assign req_ready = seq_idle_i && (!req_sel || init_i);
  assign start_o   = req_valid && req_sel && !init_i && seq_idle_i;
  assign accept    = req_valid && req_ready;

  assign mem_addr  = idx_q[ADDR_W-1:0];
  assign mem_we    = accept && req_sel && req_write;
  assign mem_wdata = req_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= accept && !req_write;
      if (accept && !req_sel && req_write)
        idx_q <= req_wdata[IDX_W-1:0];
      if (accept && !req_write)
        rsp_rdata <= req_sel ? mem_rdata : DATA_W'(idx_q);
    end
  end

  // R7: a data access only completes once the pass has finished
  assert_data_after_init_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_sel) |-> init_i);

  // R5: no request is taken while the pass runs
  assert_stall_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_idle_i |-> !req_ready);

  // R2: an index read returns zero above the index width
  assert_idx_read_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_sel && !req_write)
      |=> (rsp_rdata[DATA_W-1:IDX_W] == '0));

endmodule

// File: rtl/cfgram_indexed.sv
module cfgram_indexed #(
  parameter int IDX_W      = 7,
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 8,
  parameter int SUM_LO     = 'h10,
  parameter int SUM_HI     = 'h2C,
  parameter int CK_HI_ADDR = 'h2E,
  parameter int CK_LO_ADDR = 'h2F,
  parameter int FILL_MUL   = 29,
  parameter int FILL_ADD   = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_sel,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              busy,
  output logic              init_done
);

  localparam int SUM_W = 2 * DATA_W;

  logic [ADDR_W-1:0] mem_addr;
  logic              mem_we;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata;
  logic [ADDR_W-1:0] seq_addr;
  logic [DATA_W-1:0] seq_rdata;
  logic              ck_we;
  logic [SUM_W-1:0]  ck_value;
  logic              start;

  cfgram_front #(
    .IDX_W (IDX_W),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_sel   (req_sel),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .init_i    (init_done),
    .seq_idle_i(!busy),
    .start_o   (start),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  cfgram_sumseq #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .SUM_W (SUM_W),
    .SUM_LO(SUM_LO),
    .SUM_HI(SUM_HI)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .seq_addr_o (seq_addr),
    .seq_rdata_i(seq_rdata),
    .ck_we_o    (ck_we),
    .ck_value_o (ck_value),
    .busy_o     (busy),
    .init_o     (init_done)
  );

  cfgram_store #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .SUM_W     (SUM_W),
    .FILL_MUL  (FILL_MUL),
    .FILL_ADD  (FILL_ADD),
    .CK_HI_ADDR(CK_HI_ADDR),
    .CK_LO_ADDR(CK_LO_ADDR)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (mem_addr),
    .bus_we   (mem_we),
    .bus_wdata(mem_wdata),
    .bus_rdata(mem_rdata),
    .seq_addr (seq_addr),
    .seq_rdata(seq_rdata),
    .ck_we    (ck_we),
    .ck_value (ck_value)
  );

  // R9: the pass only starts for a data-port request
  assert_start_data_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid && req_sel));

endmodule

// File: tb/tb_cfgram_indexed.sv
`timescale 1ns/1ps
module tb_cfgram_indexed;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_sel, req_write;
  logic [7:0] req_wdata;
  logic       req_ready, rsp_valid, busy, init_done;
  logic [7:0] rsp_rdata;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  cfgram_indexed dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_sel(req_sel), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .busy(busy), .init_done(init_done)
  );

  function automatic logic [7:0] fill(int a);
    int t;
    t = 29 * a + 17;
    return t[7:0];
  endfunction

  function automatic logic [15:0] exp_sum();
    logic [15:0] s;
    s = '0;
    for (int a = 'h10; a <= 'h2C; a++) s = s + 16'(fill(a));
    return s;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_sel = 1'b0; req_write = 1'b0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // One request; returns read data, busy cycles waited, and response flag.
  task automatic access(input bit sel, input bit wr, input logic [7:0] wd,
                        output logic [7:0] rd, output int waited, output bit got);
    int guard;
    @(negedge clk);
    req_valid = 1'b1; req_sel = sel; req_write = wr; req_wdata = wd;
    waited = 0; guard = 0;
    #1;
    while (!req_ready && guard < 1000) begin
      @(negedge clk); #1;
      if (busy) waited++;
      guard++;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    got = rsp_valid;
    rd  = rsp_rdata;
  endtask

  task automatic set_index(logic [7:0] v);
    logic [7:0] rd; int w; bit g;
    access(1'b0, 1'b1, v, rd, w, g);
  endtask

  task automatic read_byte(logic [7:0] idx, output logic [7:0] rd, output int w);
    bit g;
    set_index(idx);
    access(1'b1, 1'b0, 8'h00, rd, w, g);
  endtask

  task automatic t_reset_state();
    apply_reset();
    #1;
    chk("R1 busy", busy, 0);
    chk("R1 init_done", init_done, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    req_sel = 1'b0; #1;
    chk("R1 req_ready", req_ready, 1);
  endtask

  task automatic t_index_port();
    logic [7:0] rd; int w; bit g;
    apply_reset();
    access(1'b0, 1'b1, 8'hC5, rd, w, g);
    chk("R10 no rsp on write", g, 0);
    access(1'b0, 1'b0, 8'h00, rd, w, g);
    chk("R2 index readback", rd, 8'h45);
    chk("R10 rsp on read", g, 1);
    chk("R9 busy after index ops", busy, 0);
    chk("R9 init_done after index ops", init_done, 0);
    chk("R9 no wait on index", w, 0);
  endtask

  task automatic t_first_read();
    logic [7:0] rd; int w; bit g;
    logic [15:0] s;
    s = exp_sum();
    apply_reset();
    set_index(8'h2E);
    access(1'b1, 1'b0, 8'h00, rd, w, g);
    chk("R5 busy cycles on first access", w, 29);
    chk("R6 high sum byte", rd, s[15:8]);
    chk("R10 rsp after stall", g, 1);
    chk("R8 init_done set", init_done, 1);
    read_byte(8'h2F, rd, w);
    chk("R6 low sum byte", rd, s[7:0]);
    chk("R8 no busy after init", w, 0);
    read_byte(8'h10, rd, w);
    chk("R4 reset byte 0x10", rd, fill('h10));
    read_byte(8'h3A, rd, w);
    chk("R4 reset byte 0x3A", rd, fill('h3A));
  endtask

  task automatic t_wrap();
    logic [7:0] rd; int w; bit g;
    read_byte(8'h45, rd, w);
    chk("R3 index 0x45 wraps to 0x05", rd, fill('h05));
    set_index(8'h7F);
    access(1'b1, 1'b1, 8'h9C, rd, w, g);
    read_byte(8'h3F, rd, w);
    chk("R3 write via 0x7F lands at 0x3F", rd, 8'h9C);
  endtask

  task automatic t_first_write();
    logic [7:0] rd; int w; bit g;
    logic [15:0] s;
    s = exp_sum();
    apply_reset();
    set_index(8'h20);
    access(1'b1, 1'b1, 8'hAB, rd, w, g);
    chk("R5 busy cycles on first write", w, 29);
    read_byte(8'h2E, rd, w);
    chk("R7 sum hi ignores first write", rd, s[15:8]);
    read_byte(8'h2F, rd, w);
    chk("R7 sum lo ignores first write", rd, s[7:0]);
    read_byte(8'h20, rd, w);
    chk("R7 first write stored", rd, 8'hAB);
    set_index(8'h10);
    access(1'b1, 1'b1, 8'h11, rd, w, g);
    chk("R8 later write no busy", w, 0);
    read_byte(8'h2F, rd, w);
    chk("R8 sum lo not recomputed", rd, s[7:0]);
    chk("R8 init_done sticky", init_done, 1);
  endtask

  task automatic t_first_write_ck();
    logic [7:0] rd; int w; bit g;
    logic [15:0] s;
    s = exp_sum();
    apply_reset();
    set_index(8'h2F);
    access(1'b1, 1'b1, 8'h5A, rd, w, g);
    read_byte(8'h2F, rd, w);
    chk("R7 first write overrides sum lo", rd, 8'h5A);
    read_byte(8'h2E, rd, w);
    chk("R6 sum hi kept", rd, s[15:8]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset_state();
    t_index_port();
    t_first_read();
    t_wrap();
    t_first_write();
    t_first_write_ck();
    finish_run();
  end

endmodule